// File: doc/BRIEF.md
# Configurable GPIO Pin Mode Logic

This block sits between a GPIO register bank and a row of pads. For every pin it takes the configuration fields (mode, output type, pull selection), the output data bit and the alternate-function data and transmit-enable from a peripheral. From these it produces the pad controls: low-side drive enable, high-side drive enable, pull-up enable, pull-down enable and input-buffer enable.

It also samples the pad once per clock into a logical input value. The register bank and the peripherals both read this value.

Each pin is configured on its own, so a single instance can mix input, output, alternate-function and analog pins. The pad controls are combinational from the configuration inputs. The logical input is registered and lags the pad by one clock.

Top module: `gpio_pin_mode`

## Requirements
- R1: Pins with mode code 00 (input) enable no driver and turn the input buffer on. Pull-up follows pull code 01 and pull-down follows pull code 10.
- R2: With mode code 01 (output) and output-type bit 1 (open-drain), a data bit of 0 turns on the low-side driver and a data bit of 1 turns on no driver. The high-side driver is never enabled in this case.
- R3: With mode code 01 and output-type bit 0 (push-pull), a data bit of 0 turns on only the low-side driver and a data bit of 1 turns on only the high-side driver.
- R4: With mode code 10 (alternate function) and the peripheral transmit enable at 1, the peripheral data bit drives the pin. The output-type bit selects open-drain or push-pull in the same way as in R2 and R3.
- R5: With mode code 10 and the peripheral transmit enable at 0, neither driver is on.
- R6: With mode codes 01 and 10, the input buffer stays on and the pulls follow the pull code as in R1.
- R7: With mode code 11 (analog), no driver, no pull and no input buffer is on. The logical input of that pin reads 0 whatever the pad level is.
- R8: Pull code 11 enables neither pull in any mode.
- R9: The low-side and high-side drive enables of a pin are never both 1, for any combination of inputs.
- R10: The logical input is 0 out of reset. After each clock edge it equals the pad level sampled at that edge for every pin whose input buffer is on, and 0 for every other pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2*PINS | Mode per pin: 00 input, 01 output, 10 alternate function, 11 analog |
| cfg_odrain | input | PINS | Output type per pin: 1 open-drain, 0 push-pull |
| cfg_pull | input | 2*PINS | Pull per pin: 01 up, 10 down, 00 or 11 none |
| out_bit | input | PINS | Register output data |
| alt_bit | input | PINS | Peripheral output data |
| alt_txen | input | PINS | Peripheral transmit enable |
| pad_lvl | input | PINS | Level seen at the pad |
| drv_lo | output | PINS | Low-side drive enable |
| drv_hi | output | PINS | High-side drive enable |
| pull_up | output | PINS | Pull-up enable |
| pull_dn | output | PINS | Pull-down enable |
| rx_en | output | PINS | Input-buffer enable |
| pin_val | output | PINS | Registered logical input |

## Verification
The bench sets an analog pin against a pad held high. A design that leaves the input buffer on, or skips the zero forcing, would report a 1 on that pin. It also drives open-drain pins with a 1, where a design that treated them as push-pull would enable the high-side driver. With the transmit enable low in alternate-function mode, a design that ignored the enable would drive peripheral data. Pull code 11 is mixed into every mode, and a design that decoded only one bit of the pull field would turn on a pull there. Random configurations cover mixed pins, and every vector is checked for contention between the two drivers.

// File: rtl/gpio_pin_mode.sv
module gpio_pin_mode #(
  parameter int PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*PINS-1:0] cfg_mode,
  input  logic [PINS-1:0]   cfg_odrain,
  input  logic [2*PINS-1:0] cfg_pull,
  input  logic [PINS-1:0]   out_bit,
  input  logic [PINS-1:0]   alt_bit,
  input  logic [PINS-1:0]   alt_txen,
  input  logic [PINS-1:0]   pad_lvl,
  output logic [PINS-1:0]   drv_lo,
  output logic [PINS-1:0]   drv_hi,
  output logic [PINS-1:0]   pull_up,
  output logic [PINS-1:0]   pull_dn,
  output logic [PINS-1:0]   rx_en,
  output logic [PINS-1:0]   pin_val
);

  logic [PINS-1:0] rx_gated;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [1:0] md, pl;
    logic       en, dat;
    assign md = cfg_mode[2*i +: 2];
    assign pl = cfg_pull[2*i +: 2];

    always_comb begin
      en  = 1'b0;
      dat = 1'b0;
      unique case (md)
        2'b01:   begin en = 1'b1;        dat = out_bit[i]; end
        2'b10:   begin en = alt_txen[i]; dat = alt_bit[i]; end
        default: begin en = 1'b0;        dat = 1'b0;       end
      endcase
    end

    assign rx_en[i]    = (md != 2'b11);
    assign drv_lo[i]   = en & ~dat;
    assign drv_hi[i]   = en & dat & ~cfg_odrain[i];
    assign pull_up[i]  = rx_en[i] & (pl == 2'b01);
    assign pull_dn[i]  = rx_en[i] & (pl == 2'b10);
    assign rx_gated[i] = rx_en[i] & pad_lvl[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_val <= '0;
    else        pin_val <= rx_gated;

endmodule

module gpio_pin_mode_chk #(
  parameter int PINS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2*PINS-1:0] cfg_mode,
  input logic [PINS-1:0]   cfg_odrain,
  input logic [PINS-1:0]   pad_lvl,
  input logic [PINS-1:0]   drv_lo,
  input logic [PINS-1:0]   drv_hi,
  input logic [PINS-1:0]   pull_up,
  input logic [PINS-1:0]   pull_dn,
  input logic [PINS-1:0]   rx_en,
  input logic [PINS-1:0]   pin_val
);
  logic [PINS-1:0] analog, outmode;
  for (genvar i = 0; i < PINS; i++) begin : g_m
    assign analog[i]  = (cfg_mode[2*i +: 2] == 2'b11);
    assign outmode[i] = (cfg_mode[2*i +: 2] == 2'b01);
  end

  p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_lo & drv_hi) == '0);
  p_one_pull_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_up & pull_dn) == '0);
  p_od_no_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_hi & cfg_odrain) == '0);
  p_analog_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((drv_lo | drv_hi | pull_up | pull_dn | rx_en) & analog) == '0);
  p_output_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((outmode & ~cfg_odrain) & ~(drv_lo | drv_hi)) == '0);
  p_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pin_val == ($past(pad_lvl) & $past(~analog)));
  p_analog_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(analog) != '0 |-> (pin_val & $past(analog)) == '0);
endmodule

bind gpio_pin_mode gpio_pin_mode_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_odrain(cfg_odrain),
  .pad_lvl(pad_lvl), .drv_lo(drv_lo), .drv_hi(drv_hi), .pull_up(pull_up),
  .pull_dn(pull_dn), .rx_en(rx_en), .pin_val(pin_val));

// File: tb/tb_gpio_pin_mode.sv
module tb_gpio_pin_mode;
  localparam int P = 16;
  logic clk = 0, rst_n = 0;
  logic [2*P-1:0] cfg_mode = '0, cfg_pull = '0;
  logic [P-1:0] cfg_odrain = '0, out_bit = '0, alt_bit = '0, alt_txen = '0, pad_lvl = '0;
  logic [P-1:0] drv_lo, drv_hi, pull_up, pull_dn, rx_en, pin_val;
  int errors = 0, checks = 0;
  logic [P-1:0] exp_in;

  always #4 clk = ~clk;

  gpio_pin_mode #(.PINS(P)) dut (.*);

  function automatic logic [4:0] model(int i);
    logic [1:0] m, pl; logic en, d, ie;
    m = cfg_mode[2*i +: 2]; pl = cfg_pull[2*i +: 2];
    ie = (m != 2'b11);
    en = (m == 2'b01) ? 1'b1 : (m == 2'b10) ? alt_txen[i] : 1'b0;
    d  = (m == 2'b01) ? out_bit[i] : alt_bit[i];
    return {en & ~d, en & d & ~cfg_odrain[i], ie & (pl == 2'b01), ie & (pl == 2'b10), ie};
  endfunction

  function automatic logic [P-1:0] model_in();
    logic [P-1:0] r;
    for (int i = 0; i < P; i++) r[i] = model(i)[0] & pad_lvl[i];
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_pins();
    for (int i = 0; i < P; i++) begin
      logic [4:0] e; logic [1:0] m; string td, tp;
      e = model(i); m = cfg_mode[2*i +: 2];
      case (m)
        2'b00: begin td = "R1"; tp = "R1"; end
        2'b01: begin td = cfg_odrain[i] ? "R2" : "R3"; tp = "R6"; end
        2'b10: begin td = alt_txen[i] ? "R4" : "R5"; tp = "R6"; end
        default: begin td = "R7"; tp = "R7"; end
      endcase
      if (cfg_pull[2*i +: 2] == 2'b11) tp = "R8";
      check(td, {30'd0, drv_lo[i], drv_hi[i]}, {30'd0, e[4:3]});
      check(tp, {29'd0, pull_up[i], pull_dn[i], rx_en[i]}, {29'd0, e[2:0]});
    end
    check("R9", drv_lo & drv_hi, 0);
  endtask

  task automatic apply(logic [2*P-1:0] m, logic [P-1:0] ot, logic [2*P-1:0] pl,
                       logic [P-1:0] od, logic [P-1:0] ad, logic [P-1:0] ae, logic [P-1:0] pin);
    @(negedge clk);
    check("R10", pin_val, exp_in);
    cfg_mode = m; cfg_odrain = ot; cfg_pull = pl; out_bit = od;
    alt_bit = ad; alt_txen = ae; pad_lvl = pin;
    #1;
    check_pins();
    exp_in = model_in();
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    exp_in = '0;
    repeat (2) @(negedge clk);
    check("R10", pin_val, 0);
    rst_n = 1;
    // input mode, every pull code
    apply({P{2'b00}}, '0, {4{8'b11100100}}, '1, '1, '1, 16'hA5C3);
    // analog with pad high: R7
    apply({P{2'b11}}, '0, {4{8'b11100100}}, '1, '1, '1, '1);
    // open-drain and push-pull outputs
    apply({P{2'b01}}, 16'hFF00, {P{2'b11}}, 16'hF0F0, '0, '0, 16'h1234);
    // alternate function, mixed enable and type
    apply({P{2'b10}}, 16'hCCCC, {P{2'b01}}, '0, 16'hAAAA, 16'hF0F0, 16'hFFFF);
    apply({P{2'b10}}, '0, {P{2'b10}}, '1, '1, '0, '0);
    for (int k = 0; k < 2000; k++)
      apply({$urandom, $urandom} , $urandom, {$urandom}, $urandom, $urandom, $urandom, $urandom);
    @(negedge clk);
    check("R10", pin_val, exp_in);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule